// File: doc/BRIEF.md
# VLIW ALU Bundle Parser

This block takes a stream of 64-bit instruction words and packs them into wide ALU bundles that a shader core can issue in one step. A bundle is one to seven words long. It starts with one to five scalar operation words and may end with up to two literal-constant words. Each operation word names its target slot: one of four vector lanes or the single slot that can run transcendental functions. The parser places the operation in that slot, collects the literal words that follow the final operation, and presents the whole bundle on a registered output once its last word has arrived.

Words enter through a valid/ready handshake. A completed bundle leaves through a second valid/ready handshake as a slot-valid mask, five slot words and two literal words. Malformed input raises a one-cycle error pulse on one of three flags and the bundle is dropped. The three cases are an illegal slot or literal-count encoding, two operations aimed at the same slot, and more than five operations without an end mark. After such an error the parser returns to a clean state.

Top module: `vliwBundleParser`

## Requirements
- R1: After reset `outValid` and all three error flags are 0, and `inReady` is 1.
- R2: Bits 60:58 of an operation word pick its slot. Codes 0 to 3 are vector lanes and code 4 is the transcendental slot. The whole 64-bit word appears at `outOps[slot*64 +: 64]` with `outMask[slot]` set. Slots not used by the bundle read as zero with their mask bit clear.
- R3: Bit 63 set marks the final operation of a bundle. Bits 62:61 of that word give how many literal words (0 to 2) follow it. Literal i appears at `outLits[i*64 +: 64]` and unused literal positions read as zero.
- R4: A good bundle is presented on `outValid` in the cycle right after its final word (the last operation or the last literal) is accepted.
- R5: A word is accepted when `inValid && inReady`. `inReady` equals `!outValid || outReady`. While `outValid && !outReady`, `outValid`, `outMask`, `outOps` and `outLits` stay unchanged.
- R6: A slot code of 5, 6 or 7, or a literal count of 3 on a final operation, pulses `errEncoding` for one cycle after that word and the bundle is not emitted. When the count is valid, its literal words are still consumed. A count of 3 is treated as zero literals.
- R7: An operation aimed at a slot already taken in the same bundle pulses `errConflict` for one cycle after that word and the bundle is not emitted.
- R8: An operation word that arrives after five operations without an end mark pulses `errOverflow` for one cycle after that word. That word and its bundle are discarded, and the next word starts a new bundle.
- R9: Each accepted word raises at most one error flag. Overflow takes priority over encoding, and encoding takes priority over conflict.
- R10: Every emitted bundle has at least one bit set in `outMask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input word offered |
| inReady | output | 1 | Parser can take a word |
| inWord | input | 64 | Instruction word |
| outValid | output | 1 | Bundle available |
| outReady | input | 1 | Consumer takes bundle |
| outMask | output | 5 | Slot-valid mask, bit 4 is the transcendental slot |
| outOps | output | 320 | Five slot words, slot n at bits n*64 +: 64 |
| outLits | output | 128 | Two literal words |
| errEncoding | output | 1 | Illegal slot or literal-count encoding |
| errConflict | output | 1 | Two operations in one bundle share a slot |
| errOverflow | output | 1 | Sixth operation without an end mark |

## Verification
The bench targets the edges of bundle framing, and a wrong design fails each one in a visible way.
- A full five-operation bundle with two literals: a design that miscounts literal words would merge the next bundle's first operation into a literal position.
- A sixth operation: a parser that fails to resynchronise would misframe every bundle that follows, so the bench sends a good bundle right after the overflow.
- Duplicate slots and a bad slot code on a final word that still carries literals: a design that stops consuming those literals would treat literal data as operation words.
- Long stretches with `outReady` low: a design that lets a new bundle overwrite one still waiting would lose bundles.

// File: rtl/bundlePkg.sv
package bundlePkg;
  localparam int WORD_W    = 64;
  localparam int NUM_SLOTS = 5;
  localparam int MAX_OPS   = NUM_SLOTS;
  localparam int MAX_LITS  = 2;
  localparam int SLOT_W    = 3;
  localparam int LITC_W    = 2;
  localparam int LAST_BIT  = 63;
  localparam int LITC_LO   = 61;
  localparam int SLOT_LO   = 58;
  localparam int CTL_W     = WORD_W - SLOT_LO;
  localparam int OPC_W     = $clog2(MAX_OPS + 1);
  localparam int LIT_IDX_W = (MAX_LITS > 1) ? $clog2(MAX_LITS) : 1;

  typedef enum logic {ST_OPS, ST_LITS} parseStateT;

  typedef struct packed {
    logic                 opWe;
    logic [SLOT_W-1:0]    opSel;
    logic                 litWe;
    logic [LIT_IDX_W-1:0] litSel;
    logic                 loadOut;
    logic                 clearAsm;
    logic [NUM_SLOTS-1:0] outMask;
  } strobeT;
endpackage

// File: rtl/bundleCtrl.sv
module bundleCtrl
  import bundlePkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [CTL_W-1:0] ctlBits,
  input  logic             outValid,
  input  logic             outReady,
  output logic             inReady,
  output strobeT           strb,
  output logic             errEncoding,
  output logic             errConflict,
  output logic             errOverflow
);
  localparam int LAST_OFF = LAST_BIT - SLOT_LO;
  localparam int LITC_OFF = LITC_LO - SLOT_LO;

  parseStateT           state, stateN;
  logic [OPC_W-1:0]     opCount, opCountN;
  logic [NUM_SLOTS-1:0] usedMask, usedMaskN;
  logic                 bad, badN;
  logic [LITC_W-1:0]    litLeft, litLeftN;
  logic [LIT_IDX_W-1:0] litIdx, litIdxN;
  logic                 encN, cnfN, ovfN;

  logic                 accept, isLast, slotBad, litBad, dup, full;
  logic [LITC_W-1:0]    litCnt;
  logic [SLOT_W-1:0]    slotCode;
  logic [NUM_SLOTS-1:0] slotHot;

  assign inReady  = !outValid || outReady;
  assign accept   = inValid && inReady;
  assign isLast   = ctlBits[LAST_OFF];
  assign litCnt   = ctlBits[LITC_OFF +: LITC_W];
  assign slotCode = ctlBits[0 +: SLOT_W];
  assign slotBad  = slotCode >= SLOT_W'(NUM_SLOTS);
  assign litBad   = isLast && (litCnt > LITC_W'(MAX_LITS));
  assign slotHot  = slotBad ? '0 : (NUM_SLOTS'(1) << slotCode);
  assign dup      = |(usedMask & slotHot);
  assign full     = opCount == OPC_W'(MAX_OPS);

  always_comb begin
    stateN    = state;
    opCountN  = opCount;
    usedMaskN = usedMask;
    badN      = bad;
    litLeftN  = litLeft;
    litIdxN   = litIdx;
    encN      = 1'b0;
    cnfN      = 1'b0;
    ovfN      = 1'b0;
    strb      = '0;
    if (accept) begin
      if (state == ST_OPS) begin
        if (full) begin
          ovfN          = 1'b1;
          strb.clearAsm = 1'b1;
          opCountN      = '0;
          usedMaskN     = '0;
          badN          = 1'b0;
        end else begin
          encN = slotBad || litBad;
          cnfN = !encN && dup;
          if (!slotBad && !dup) begin
            strb.opWe  = 1'b1;
            strb.opSel = slotCode;
            usedMaskN  = usedMask | slotHot;
          end
          badN = bad || slotBad || litBad || dup;
          if (isLast) begin
            if (litCnt == '0 || litBad) begin
              strb.loadOut  = !badN;
              strb.outMask  = usedMaskN;
              strb.clearAsm = 1'b1;
              opCountN      = '0;
              usedMaskN     = '0;
              badN          = 1'b0;
            end else begin
              stateN   = ST_LITS;
              litLeftN = litCnt;
              litIdxN  = '0;
            end
          end else begin
            opCountN = opCount + OPC_W'(1);
          end
        end
      end else begin
        strb.litWe  = 1'b1;
        strb.litSel = litIdx;
        if (litLeft == LITC_W'(1)) begin
          strb.loadOut  = !bad;
          strb.outMask  = usedMask;
          strb.clearAsm = 1'b1;
          stateN        = ST_OPS;
          opCountN      = '0;
          usedMaskN     = '0;
          badN          = 1'b0;
          litLeftN      = '0;
          litIdxN       = '0;
        end else begin
          litLeftN = litLeft - LITC_W'(1);
          litIdxN  = litIdx + LIT_IDX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_OPS;
      opCount     <= '0;
      usedMask    <= '0;
      bad         <= 1'b0;
      litLeft     <= '0;
      litIdx      <= '0;
      errEncoding <= 1'b0;
      errConflict <= 1'b0;
      errOverflow <= 1'b0;
    end else begin
      state       <= stateN;
      opCount     <= opCountN;
      usedMask    <= usedMaskN;
      bad         <= badN;
      litLeft     <= litLeftN;
      litIdx      <= litIdxN;
      errEncoding <= encN;
      errConflict <= cnfN;
      errOverflow <= ovfN;
    end
  end

  // R8: after an overflow the parser sits at the start of a fresh bundle
  a_r8_resync: assert property (@(posedge clk) disable iff (!rstN)
    errOverflow |-> (state == ST_OPS && opCount == '0 && usedMask == '0));
  // R9: never more than one error flag per word
  a_r9_one_flag: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({errEncoding, errConflict, errOverflow}));
  // R8: operation count stays within the slot budget
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    opCount <= OPC_W'(MAX_OPS));
  // R5: a waiting bundle is never overwritten
  a_r5_no_overwrite: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !strb.loadOut);
endmodule

// File: rtl/bundleData.sv
module bundleData
  import bundlePkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [WORD_W-1:0]             inWord,
  input  strobeT                        strb,
  input  logic                          outReady,
  output logic                          outValid,
  output logic [NUM_SLOTS-1:0]          outMask,
  output logic [NUM_SLOTS*WORD_W-1:0]   outOps,
  output logic [MAX_LITS*WORD_W-1:0]    outLits
);
  logic [WORD_W-1:0] asmOps  [NUM_SLOTS];
  logic [WORD_W-1:0] opsNext [NUM_SLOTS];
  logic [WORD_W-1:0] asmLits [MAX_LITS];
  logic [WORD_W-1:0] litsNext[MAX_LITS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign opsNext[g] = (strb.opWe && strb.opSel == SLOT_W'(g)) ? inWord : asmOps[g];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        asmOps[g]               <= '0;
        outOps[g*WORD_W +: WORD_W] <= '0;
      end else begin
        asmOps[g] <= strb.clearAsm ? '0 : opsNext[g];
        if (strb.loadOut) outOps[g*WORD_W +: WORD_W] <= opsNext[g];
      end
    end
    // R2: an unused slot reads as zero
    a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
      (outValid && !outMask[g]) |-> (outOps[g*WORD_W +: WORD_W] == '0));
  end

  for (genvar l = 0; l < MAX_LITS; l++) begin : g_lit
    assign litsNext[l] = (strb.litWe && strb.litSel == LIT_IDX_W'(l)) ? inWord : asmLits[l];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        asmLits[l]                  <= '0;
        outLits[l*WORD_W +: WORD_W] <= '0;
      end else begin
        asmLits[l] <= strb.clearAsm ? '0 : litsNext[l];
        if (strb.loadOut) outLits[l*WORD_W +: WORD_W] <= litsNext[l];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outMask  <= '0;
    end else begin
      if (strb.loadOut) begin
        outValid <= 1'b1;
        outMask  <= strb.outMask;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
    end
  end

  // R5: a held bundle does not change
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outMask) && $stable(outOps) && $stable(outLits)));
  // R10: every emitted bundle carries at least one operation
  a_r10_mask_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outMask != '0));
endmodule

// File: rtl/vliwBundleParser.sv
module vliwBundleParser
  import bundlePkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  output logic                        inReady,
  input  logic [63:0]                 inWord,
  output logic                        outValid,
  input  logic                        outReady,
  output logic [4:0]                  outMask,
  output logic [319:0]                outOps,
  output logic [127:0]                outLits,
  output logic                        errEncoding,
  output logic                        errConflict,
  output logic                        errOverflow
);
  strobeT strb;

  bundleCtrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .ctlBits    (inWord[WORD_W-1:SLOT_LO]),
    .outValid   (outValid),
    .outReady   (outReady),
    .inReady    (inReady),
    .strb       (strb),
    .errEncoding(errEncoding),
    .errConflict(errConflict),
    .errOverflow(errOverflow)
  );

  bundleData data_i (
    .clk     (clk),
    .rstN    (rstN),
    .inWord  (inWord),
    .strb    (strb),
    .outReady(outReady),
    .outValid(outValid),
    .outMask (outMask),
    .outOps  (outOps),
    .outLits (outLits)
  );
endmodule

// File: tb/vliwBundleParser_tb_top.sv
`timescale 1ns/1ps
module vliwBundleParser_tb_top;
  localparam int BND_W = 5 + 320 + 128;

  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic         inReady;
  logic [63:0]  inWord;
  logic         outValid;
  logic         outReady;
  logic [4:0]   outMask;
  logic [319:0] outOps;
  logic [127:0] outLits;
  logic         errEncoding, errConflict, errOverflow;

  always #2 clk = ~clk;

  vliwBundleParser dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inWord(inWord),
    .outValid(outValid), .outReady(outReady), .outMask(outMask), .outOps(outOps),
    .outLits(outLits), .errEncoding(errEncoding), .errConflict(errConflict),
    .errOverflow(errOverflow)
  );

  int testCount = 0;
  int failCount = 0;
  int readyPct  = 100;

  logic [BND_W-1:0] expQ[$];
  logic [63:0] mOps[5];
  logic [63:0] mLits[2];
  logic [4:0]  mUsed;
  int          mOpCount, mLitLeft, mLitIdx;
  bit          mInLits, mBad;
  bit          expEnc, expCnf, expOvf;

  task automatic check(input bit ok, input string req, input logic [BND_W-1:0] act,
                       input logic [BND_W-1:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mkOp(input bit last, input logic [1:0] lc, input int slot);
    logic [63:0] w;
    w = {$urandom, $urandom};
    w[63] = last;
    w[62:61] = lc;
    w[60:58] = slot[2:0];
    return w;
  endfunction

  task automatic modelClear();
    mUsed = '0; mOpCount = 0; mInLits = 0; mBad = 0; mLitLeft = 0; mLitIdx = 0;
    for (int g = 0; g < 5; g++) mOps[g] = '0;
    for (int i = 0; i < 2; i++) mLits[i] = '0;
  endtask

  task automatic modelFinish();
    logic [BND_W-1:0] b;
    if (!mBad) begin
      b = '0;
      for (int i = 0; i < 2; i++) b[i*64 +: 64] = mLits[i];
      for (int g = 0; g < 5; g++) b[128 + g*64 +: 64] = mOps[g];
      b[448 +: 5] = mUsed;
      expQ.push_back(b);
    end
    modelClear();
  endtask

  task automatic modelAccept(input logic [63:0] w);
    bit last, sb, lb, dp;
    logic [1:0] lc;
    int slot;
    last = w[63]; lc = w[62:61]; slot = int'(w[60:58]);
    if (mInLits) begin
      mLits[mLitIdx] = w; mLitIdx++; mLitLeft--;
      if (mLitLeft == 0) modelFinish();
    end else if (mOpCount == 5) begin
      expOvf = 1;
      modelClear();
    end else begin
      sb = slot >= 5;
      lb = last && lc == 2'd3;
      dp = !sb && mUsed[slot];
      if (sb || lb) expEnc = 1; else if (dp) expCnf = 1;
      if (!sb && !dp) begin mOps[slot] = w; mUsed[slot] = 1'b1; end
      if (sb || lb || dp) mBad = 1;
      if (last) begin
        if (lc == 2'd0 || lb) modelFinish();
        else begin mInLits = 1; mLitLeft = int'(lc); mLitIdx = 0; end
      end else mOpCount++;
    end
  endtask

  task automatic step(input bit v, input logic [63:0] w, output bit took);
    @(negedge clk);
    check({errEncoding, errConflict, errOverflow} == {expEnc, expCnf, expOvf},
          "R6/R7/R8/R9 flags", BND_W'({errEncoding, errConflict, errOverflow}),
          BND_W'({expEnc, expCnf, expOvf}));
    expEnc = 0; expCnf = 0; expOvf = 0;
    check(outValid == (expQ.size() != 0), "R4 bundle presence",
          BND_W'(outValid), BND_W'(expQ.size() != 0));
    outReady = ($urandom_range(0, 99) < readyPct);
    inValid  = v;
    inWord   = w;
    #1;
    check(inReady == (!outValid || outReady), "R5 ready rule",
          BND_W'(inReady), BND_W'(!outValid || outReady));
    if (outValid && outReady && expQ.size() != 0) begin
      check({outMask, outOps, outLits} == expQ[0], "R2/R3/R10 bundle contents",
            {outMask, outOps, outLits}, expQ[0]);
      void'(expQ.pop_front());
    end
    took = v && inReady;
    if (took) modelAccept(w);
  endtask

  task automatic send(input logic [63:0] w);
    bit took;
    took = 0;
    while (!took) step(1'b1, w, took);
  endtask

  task automatic idle(input int n);
    bit took;
    for (int i = 0; i < n; i++) step(1'b0, '0, took);
  endtask

  task automatic sendBundle(input int nOps, input logic [1:0] lc, input bit dupErr);
    int s[5];
    for (int i = 0; i < 5; i++) s[i] = i;
    for (int i = 4; i > 0; i--) begin
      int j, t;
      j = $urandom_range(0, i);
      t = s[i]; s[i] = s[j]; s[j] = t;
    end
    if (dupErr && nOps > 1) s[nOps-1] = s[0];
    for (int k = 0; k < nOps; k++) send(mkOp(k == nOps - 1, lc, s[k]));
    for (int k = 0; k < int'(lc) && lc != 2'd3; k++) send({$urandom, $urandom});
  endtask

  initial begin
    bit took;
    void'($urandom(32'h5eed_0417));
    rstN = 0; inValid = 0; inWord = '0; outReady = 0;
    expEnc = 0; expCnf = 0; expOvf = 0;
    modelClear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(!outValid && !errEncoding && !errConflict && !errOverflow, "R1 reset outputs",
          BND_W'({outValid, errEncoding, errConflict, errOverflow}), '0);
    check(inReady == 1'b1, "R1 reset ready", BND_W'(inReady), BND_W'(1));
    rstN = 1;
    // R2: single transcendental op
    send(mkOp(1, 2'd0, 4));
    // R3: full bundle with two literals
    for (int k = 0; k < 5; k++) send(mkOp(k == 4, 2'd2, 4 - k));
    send({$urandom, $urandom}); send({$urandom, $urandom});
    // R3: one literal
    send(mkOp(0, 2'd0, 1)); send(mkOp(1, 2'd1, 3)); send({$urandom, $urandom});
    // R7: duplicate slot
    send(mkOp(0, 2'd0, 2)); send(mkOp(1, 2'd0, 2));
    // R6: bad slot code
    send(mkOp(1, 2'd0, 6));
    // R6: literal count 3
    send(mkOp(1, 2'd3, 0));
    // R6: bad slot on last op, literals still consumed
    send(mkOp(0, 2'd0, 0)); send(mkOp(1, 2'd2, 5));
    send({$urandom, $urandom}); send({$urandom, $urandom});
    send(mkOp(1, 2'd0, 1));
    // R8: six unmarked ops then a good bundle
    for (int k = 0; k < 6; k++) send(mkOp(0, 2'd0, k % 5));
    send(mkOp(0, 2'd0, 3)); send(mkOp(1, 2'd1, 0)); send({$urandom, $urandom});
    // R9: literal count 3 with duplicate slot, encoding flag wins
    send(mkOp(0, 2'd0, 1)); send(mkOp(1, 2'd3, 1));
    // R5: heavy backpressure
    readyPct = 5;
    for (int b = 0; b < 10; b++) sendBundle($urandom_range(1, 5), 2'($urandom_range(0, 2)), 0);
    idle(20);
    // Random traffic
    for (int b = 0; b < 300; b++) begin
      readyPct = $urandom_range(30, 100);
      sendBundle($urandom_range(1, 5), 2'($urandom_range(0, 2)), $urandom_range(0, 9) == 0);
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    readyPct = 100;
    idle(5);
    check(expQ.size() == 0, "R4 all bundles drained", BND_W'(expQ.size()), '0);
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failCount++;
    testCount++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule